// File: doc/BRIEF.md
# HDLC Transmit FIFO Controller

This block is the transmit half of one HDLC channel. The host stores up to 32 payload bytes in an internal FIFO, one byte per write strobe, then releases them with a single control word write. That word carries a block length, an end-of-frame command and a transmitter reset command. The released bytes go to a downstream framer one per framer request. The framer handles bit stuffing, flags and CRC. Each byte comes with a marker that flags the final byte of a frame.

Two transmit events are reported in a status word. The first says the FIFO has drained a released block and can take the next one. The second says the framer asked for a byte in the middle of a frame and nothing was available. On an underrun the host is expected to reset the transmitter and send the whole frame again. A transparent mode streams the bytes with no frame delimiting: the end-of-frame command has no effect, and the stream stays open between blocks. Reading the status word clears the events it reports. An interrupt line is high while any reported event is pending.

Top module: `hdlc_tx_fifo`

## Requirements
- R1: After reset the status word is 0, `irq` is 0, `tx_valid` is 0, and a framer request produces neither a byte nor an underrun.
- R2: Released bytes leave in the order they were written. Each framer request that finds a released byte available presents that byte on `tx_data` with `tx_valid` high in the following cycle, for one cycle.
- R3: The block length is `ctl_word[13:8]`. The value 0 means 32 bytes, and values above 32 are treated as 32. Only that many bytes are released per control write. Once they have been sent, a request with the frame closed does nothing.
- R4: In framed mode (`mode_cfg[1]`=0), when command bit `ctl_word[0]` was set with the block, `tx_last` is high with the block's final byte only. Without that bit, no byte carries `tx_last`.
- R5: In transparent mode (`mode_cfg[1]`=1), `tx_last` is never high, and the stream stays open after every byte.
- R6: Status bit 7 (ready) becomes pending in the cycle the final byte of a released block is presented. It also becomes pending on a control write that clears the reset command while the transmitter is held in reset.
- R7: A framer request while a frame is open (a byte was sent and no end marker followed), with no released byte available, raises status bit 6 (underrun) in the next cycle and closes the frame.
- R8: While underrun is pending, status bit 7 reads 0 even if ready is pending. A read returns and clears only the underrun, and the ready bit then becomes visible.
- R9: Reading the status word (`stat_rd`) clears exactly the bits it showed. An event raised in the same cycle as the read stays pending.
- R10: While the last control write had `ctl_word[7]` set, the FIFO is empty, byte writes and framer requests are ignored, and no underrun is raised. Bytes stored before the reset are discarded.
- R11: A control write (without reset) that arrives while a released block is still being sent does not change the length or the end-of-frame setting of that block.
- R12: The FIFO holds 32 bytes. A byte write while it is full is dropped.
- R13: `irq` is high exactly when the status word is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| byte_wr | input | 1 | Store `byte_in` into the FIFO |
| byte_in | input | 8 | Payload byte from host |
| ctl_wr | input | 1 | Control word write strobe |
| ctl_word | input | 16 | Bit 0 end-of-frame, bit 7 transmitter reset, bits 13:8 length |
| mode_cfg | input | 8 | Bit 1 selects transparent streaming; other bits unused here |
| stat_rd | input | 1 | Status read strobe, clears reported bits |
| stat_word | output | 8 | Bit 7 ready, bit 6 underrun |
| irq | output | 1 | Any reported event pending |
| tx_req | input | 1 | Framer asks for one byte |
| tx_valid | output | 1 | Byte presented this cycle |
| tx_data | output | 8 | Presented byte |
| tx_last | output | 1 | Presented byte ends a frame |

## Verification
On every cycle the assertions check the following. No byte appears while the transmitter is held in reset. An end marker only follows a cycle in framed mode. An underrun always closes the frame. The length counter never exceeds the FIFO depth. A blocked write to a full FIFO leaves its fill unchanged. A status read clears a shown underrun but keeps a hidden ready event. The bench scenarios cover what needs history: the byte order across a full 32-byte block, the dropped 33rd byte, length codes 0 and 63, flushing of stale bytes across a reset, a length write ignored mid-block, and the priority and same-cycle read cases. A behavioural model is compared against the outputs on every clock.

// File: rtl/hdlc_txf_pkg.sv
package hdlc_txf_pkg;

    localparam int TXF_DEPTH       = 32;
    localparam int BYTE_W          = 8;
    localparam int CTL_W           = 16;
    localparam int STAT_W          = 8;
    localparam int LEN_LSB         = 8;
    localparam int LEN_W           = 6;
    localparam int CMD_END_BIT     = 0;
    localparam int CMD_RST_BIT     = 7;
    localparam int MODE_TRANSP_BIT = 1;
    localparam int STAT_RDY_BIT    = 7;
    localparam int STAT_UDR_BIT    = 6;

    // decoded control write
    typedef struct packed {
        logic             tx_rst;
        logic             end_msg;
        logic [LEN_W-1:0] len_field;
    } ctl_cmd_t;

    // one beat towards the framer
    typedef struct packed {
        logic              valid;
        logic              last;
        logic [BYTE_W-1:0] data;
    } tx_beat_t;

    function automatic ctl_cmd_t split_ctl(input logic [CTL_W-1:0] w);
        ctl_cmd_t c;
        c.tx_rst    = w[CMD_RST_BIT];
        c.end_msg   = w[CMD_END_BIT];
        c.len_field = w[LEN_LSB +: LEN_W];
        return c;
    endfunction

    // zero selects a full block, oversize codes saturate at the depth
    function automatic int blk_bytes(input logic [LEN_W-1:0] f, input int depth);
        if (f == '0 || int'(f) > depth)
            return depth;
        return int'(f);
    endfunction

endpackage

// File: rtl/hdlc_txf_fifo.sv
module hdlc_txf_fifo
    import hdlc_txf_pkg::*;
#(
    parameter int DEPTH = TXF_DEPTH,
    parameter int W     = BYTE_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         flush,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_idx, rd_idx;
    logic [CW-1:0] cnt;
    logic          full, push_ok, pop_ok;

    assign full    = (cnt == CW'(DEPTH));
    assign empty   = (cnt == '0);
    assign push_ok = push && !flush && !full;
    assign pop_ok  = pop && !flush && !empty;
    assign dout    = mem[rd_idx];

    function automatic logic [AW-1:0] wrap_inc(input logic [AW-1:0] i);
        return (i == AW'(DEPTH - 1)) ? '0 : i + AW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_idx <= '0;
            rd_idx <= '0;
            cnt    <= '0;
        end else begin
            if (push_ok) wr_idx <= wrap_inc(wr_idx);
            if (pop_ok)  rd_idx <= wrap_inc(rd_idx);
            case ({push_ok, pop_ok})
                2'b10:   cnt <= cnt + CW'(1);
                2'b01:   cnt <= cnt - CW'(1);
                default: cnt <= cnt;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_idx] <= din;
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (push && full && !pop && !flush) |=> $stable(cnt)); // R12

endmodule

// File: rtl/hdlc_txf_irq.sv
module hdlc_txf_irq
    import hdlc_txf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              set_rdy,
    input  logic              set_udr,
    input  logic              rd,
    output logic [STAT_W-1:0] stat_word,
    output logic              irq
);
    logic pend_rdy, pend_udr, show_rdy;

    // underrun hides ready until it has been read
    assign show_rdy = pend_rdy && !pend_udr;

    always_comb begin
        stat_word               = '0;
        stat_word[STAT_RDY_BIT] = show_rdy;
        stat_word[STAT_UDR_BIT] = pend_udr;
    end

    assign irq = show_rdy || pend_udr;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_rdy <= 1'b0;
            pend_udr <= 1'b0;
        end else begin
            pend_udr <= set_udr || (pend_udr && !rd);
            pend_rdy <= set_rdy || (pend_rdy && !(rd && show_rdy));
        end
    end

    AST_RD_CLEARS_UDR: assert property (@(posedge clk) disable iff (rst)
        (rd && pend_udr && !set_udr) |=> !pend_udr); // R9

    AST_UDR_KEEPS_RDY: assert property (@(posedge clk) disable iff (rst)
        (rd && pend_udr && pend_rdy) |=> pend_rdy); // R8

endmodule

// File: rtl/hdlc_txf_engine.sv
module hdlc_txf_engine
    import hdlc_txf_pkg::*;
#(
    parameter int DEPTH = TXF_DEPTH
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ctl_wr,
    input  ctl_cmd_t          cmd,
    input  logic              transp,
    input  logic              tx_req,
    input  logic              fifo_empty,
    input  logic [BYTE_W-1:0] fifo_dout,
    output logic              fifo_pop,
    output logic              fifo_flush,
    output tx_beat_t          beat,
    output logic              set_rdy,
    output logic              set_udr
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic             xrs_q, xme_q, in_frame;
    logic [CNT_W-1:0] blk_left;
    tx_beat_t         beat_q;
    logic             avail, send, udr, final_byte, mark_end, commit;

    assign avail      = (blk_left != '0) && !fifo_empty && !xrs_q;
    assign send       = tx_req && avail;
    assign udr        = tx_req && !avail && in_frame && !xrs_q;
    assign final_byte = send && (blk_left == CNT_W'(1));
    assign mark_end   = final_byte && xme_q && !transp;
    assign commit     = ctl_wr && !cmd.tx_rst && !xrs_q && (blk_left == '0);

    assign fifo_pop   = send;
    assign fifo_flush = xrs_q;
    assign beat       = beat_q;
    assign set_rdy    = final_byte || (ctl_wr && !cmd.tx_rst && xrs_q);
    assign set_udr    = udr;

    always_ff @(posedge clk) begin
        if (rst) begin
            xrs_q    <= 1'b0;
            xme_q    <= 1'b0;
            in_frame <= 1'b0;
            blk_left <= '0;
            beat_q   <= '0;
        end else begin
            beat_q.valid <= send;
            beat_q.last  <= mark_end;
            if (send) beat_q.data <= fifo_dout;
            if (ctl_wr) xrs_q <= cmd.tx_rst;
            if (xrs_q) begin
                blk_left <= '0;
                in_frame <= 1'b0;
            end else begin
                if (commit) begin
                    blk_left <= CNT_W'(blk_bytes(cmd.len_field, DEPTH));
                    xme_q    <= cmd.end_msg;
                end else if (send) begin
                    blk_left <= blk_left - CNT_W'(1);
                end
                if (send)
                    in_frame <= !mark_end;
                else if (udr)
                    in_frame <= 1'b0;
            end
        end
    end

    AST_QUIET_IN_RESET: assert property (@(posedge clk) disable iff (rst)
        xrs_q |=> !beat_q.valid); // R10

    AST_END_ONLY_FRAMED: assert property (@(posedge clk) disable iff (rst)
        beat_q.last |-> $past(!transp)); // R5

    AST_UDR_CLOSES: assert property (@(posedge clk) disable iff (rst)
        udr |=> !in_frame); // R7

    AST_BLK_BOUND: assert property (@(posedge clk) disable iff (rst)
        int'(blk_left) <= DEPTH); // R3

endmodule

// File: rtl/hdlc_tx_fifo.sv
module hdlc_tx_fifo
    import hdlc_txf_pkg::*;
#(
    parameter int DEPTH = TXF_DEPTH
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              byte_wr,
    input  logic [BYTE_W-1:0] byte_in,
    input  logic              ctl_wr,
    input  logic [CTL_W-1:0]  ctl_word,
    input  logic [7:0]        mode_cfg,
    input  logic              stat_rd,
    output logic [STAT_W-1:0] stat_word,
    output logic              irq,
    input  logic              tx_req,
    output logic              tx_valid,
    output logic [BYTE_W-1:0] tx_data,
    output logic              tx_last
);
    ctl_cmd_t          cmd;
    tx_beat_t          beat;
    logic              fifo_empty, fifo_pop, fifo_flush;
    logic [BYTE_W-1:0] fifo_dout;
    logic              set_rdy, set_udr;
    logic              unused_cfg;

    assign cmd        = split_ctl(ctl_word);
    assign unused_cfg = ^{ctl_word[15:14], ctl_word[6:1], mode_cfg[7:2], mode_cfg[0]};

    hdlc_txf_fifo #(.DEPTH(DEPTH), .W(BYTE_W)) u_fifo (
        .clk   (clk),
        .rst   (rst),
        .flush (fifo_flush),
        .push  (byte_wr),
        .din   (byte_in),
        .pop   (fifo_pop),
        .dout  (fifo_dout),
        .empty (fifo_empty)
    );

    hdlc_txf_engine #(.DEPTH(DEPTH)) u_engine (
        .clk        (clk),
        .rst        (rst),
        .ctl_wr     (ctl_wr),
        .cmd        (cmd),
        .transp     (mode_cfg[MODE_TRANSP_BIT]),
        .tx_req     (tx_req),
        .fifo_empty (fifo_empty),
        .fifo_dout  (fifo_dout),
        .fifo_pop   (fifo_pop),
        .fifo_flush (fifo_flush),
        .beat       (beat),
        .set_rdy    (set_rdy),
        .set_udr    (set_udr)
    );

    hdlc_txf_irq u_irq (
        .clk       (clk),
        .rst       (rst),
        .set_rdy   (set_rdy),
        .set_udr   (set_udr),
        .rd        (stat_rd),
        .stat_word (stat_word),
        .irq       (irq)
    );

    assign tx_valid = beat.valid;
    assign tx_data  = beat.data;
    assign tx_last  = beat.last;

endmodule

// File: tb/tb_hdlc_tx_fifo.sv
module tb_hdlc_tx_fifo;

    logic        clk = 1'b0, rst = 1'b1;
    logic        byte_wr = 1'b0, ctl_wr = 1'b0, stat_rd = 1'b0, tx_req = 1'b0;
    logic [7:0]  byte_in = '0, mode_cfg = '0;
    logic [15:0] ctl_word = '0;
    logic [7:0]  stat_word, tx_data;
    logic        irq, tx_valid, tx_last;

    int checks = 0, errors = 0;

    always #10 clk = ~clk;

    hdlc_tx_fifo dut (
        .clk(clk), .rst(rst), .byte_wr(byte_wr), .byte_in(byte_in),
        .ctl_wr(ctl_wr), .ctl_word(ctl_word), .mode_cfg(mode_cfg),
        .stat_rd(stat_rd), .stat_word(stat_word), .irq(irq),
        .tx_req(tx_req), .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference
    logic [7:0] mq[$];
    int   m_blk = 0;
    bit   m_xme = 0, m_inf = 0, m_xrs = 0, m_prdy = 0, m_pudr = 0;
    bit   e_valid = 0, e_last = 0;
    logic [7:0] e_data = '0;

    always @(posedge clk) begin
        if (rst) begin
            mq.delete(); m_blk = 0; m_xme = 0; m_inf = 0; m_xrs = 0;
            m_prdy = 0; m_pudr = 0; e_valid = 0; e_last = 0;
        end else begin
            bit avail, snd, udr, rdy, cxrs;
            int lenv, old_sz, old_blk;
            old_sz  = mq.size();
            old_blk = m_blk;
            avail = (m_blk > 0) && (old_sz > 0) && !m_xrs;
            snd   = tx_req && avail;
            udr   = tx_req && !avail && m_inf && !m_xrs;
            cxrs  = ctl_word[7];
            lenv  = int'(ctl_word[13:8]);
            if (lenv == 0 || lenv > 32) lenv = 32;
            rdy   = (snd && m_blk == 1) || (ctl_wr && !cxrs && m_xrs);
            e_valid = snd;
            e_last  = 0;
            if (snd) begin
                e_data = mq.pop_front();
                e_last = (m_blk == 1) && m_xme && !mode_cfg[1];
                m_blk--;
                m_inf = !e_last;
            end
            if (udr) m_inf = 0;
            if (m_xrs) begin
                mq.delete(); m_blk = 0; m_inf = 0;
            end else begin
                if (byte_wr && old_sz < 32) mq.push_back(byte_in);
                if (ctl_wr && !cxrs && old_blk == 0) begin
                    m_blk = lenv; m_xme = ctl_word[0];
                end
            end
            if (ctl_wr) m_xrs = cxrs;
            if (stat_rd) begin
                if (m_pudr) m_pudr = 0;
                else if (m_prdy) m_prdy = 0;
            end
            if (rdy) m_prdy = 1;
            if (udr) m_pudr = 1;
        end
    end

    // per-clock comparison and capture
    logic [8:0] got[$];
    always @(negedge clk) begin
        if (!rst) begin
            logic [7:0] es;
            es = {m_prdy && !m_pudr, m_pudr, 6'b0};
            chk(tx_valid == e_valid, "R2 tx_valid", tx_valid, e_valid);
            if (e_valid) begin
                chk(tx_data == e_data, "R2 tx_data", tx_data, e_data);
                chk(tx_last == e_last, "R4 tx_last", tx_last, e_last);
            end
            chk(stat_word == es, "R8 stat_word", stat_word, es);
            chk(irq == (es != 0), "R13 irq", irq, es != 0);
            if (tx_valid) got.push_back({tx_last, tx_data});
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask
    task automatic push_seq(input int n, input int base);
        for (int i = 0; i < n; i++) begin
            byte_wr = 1'b1; byte_in = 8'(base + i);
            @(negedge clk);
        end
        byte_wr = 1'b0;
    endtask
    task automatic ctl(input logic [15:0] w);
        ctl_wr = 1'b1; ctl_word = w;
        @(negedge clk);
        ctl_wr = 1'b0;
    endtask
    task automatic req(input int n);
        for (int i = 0; i < n; i++) begin
            tx_req = 1'b1;
            @(negedge clk);
        end
        tx_req = 1'b0;
    endtask
    task automatic rd_stat();
        stat_rd = 1'b1;
        @(negedge clk);
        stat_rd = 1'b0;
    endtask
    task automatic expect_got(input int n, input int base, input int last_idx, input string tag);
        chk(got.size() == n, {tag, " byte count"}, got.size(), n);
        for (int i = 0; i < got.size() && i < n; i++) begin
            chk(got[i][7:0] == 8'(base + i), {tag, " byte value"}, got[i][7:0], 8'(base + i));
            chk(got[i][8] == (i == last_idx), {tag, " end marker"}, got[i][8], i == last_idx);
        end
        got.delete();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        idle(3);
        rst = 1'b0;
        idle(1);
        // R1 reset state and idle request
        chk(stat_word == 8'h00, "R1 stat after reset", stat_word, 0);
        chk(irq == 1'b0, "R1 irq after reset", irq, 0);
        chk(tx_valid == 1'b0, "R1 tx_valid after reset", tx_valid, 0);
        req(1); idle(2);
        chk(got.size() == 0, "R1 no byte when idle", got.size(), 0);
        chk(stat_word == 8'h00, "R1 no underrun when idle", stat_word, 0);

        // R6 releasing transmitter reset raises ready
        ctl(16'h0080); ctl(16'h0000); idle(1);
        chk(stat_word == 8'h80, "R6 ready on reset release", stat_word, 8'h80);
        chk(irq == 1'b1, "R13 irq with ready", irq, 1);
        rd_stat(); idle(1);
        chk(stat_word == 8'h00, "R9 read clears ready", stat_word, 0);

        // R2 R4 framed block of 5 with end marker
        push_seq(5, 8'h10); ctl(16'h0501); req(5); idle(2);
        expect_got(5, 8'h10, 4, "R4 framed block");
        chk(stat_word == 8'h80, "R6 ready after block", stat_word, 8'h80);
        rd_stat();

        // R3 R12 R7 R8 length code 0, 33rd byte dropped, underrun
        push_seq(33, 8'h40); ctl(16'h0000); req(33); idle(2);
        expect_got(32, 8'h40, -1, "R12 full block");
        chk(stat_word == 8'h40, "R8 underrun hides ready", stat_word, 8'h40);
        rd_stat(); idle(1);
        chk(stat_word == 8'h80, "R8 ready visible after read", stat_word, 8'h80);
        rd_stat(); idle(1);
        chk(stat_word == 8'h00, "R9 all cleared", stat_word, 0);

        // R3 length limit, then R10 flush
        push_seq(3, 8'hA0); ctl(16'h0201); req(3); idle(2);
        expect_got(2, 8'hA0, 1, "R3 length two");
        chk(stat_word == 8'h80, "R3 closed frame no underrun", stat_word, 8'h80);
        rd_stat();
        ctl(16'h0080); push_seq(1, 8'h55); req(2); idle(2);
        chk(got.size() == 0, "R10 no byte in reset", got.size(), 0);
        chk(stat_word == 8'h00, "R10 no underrun in reset", stat_word, 0);
        ctl(16'h0000); ctl(16'h0101); req(1); idle(2);
        chk(got.size() == 0, "R10 stale bytes flushed", got.size(), 0);
        push_seq(1, 8'h77); req(1); idle(2);
        expect_got(1, 8'h77, 0, "R10 fresh byte");
        rd_stat();

        // R3 oversize length code saturates at 32
        push_seq(32, 8'hC0); ctl(16'h3F01); req(32); idle(2);
        expect_got(32, 8'hC0, 31, "R3 code 63");
        rd_stat();

        // R5 transparent: no marker, stream stays open
        mode_cfg = 8'h02;
        push_seq(4, 8'h20); ctl(16'h0401); req(5); idle(2);
        expect_got(4, 8'h20, -1, "R5 transparent");
        chk(stat_word == 8'h40, "R5 R7 stream underrun", stat_word, 8'h40);
        rd_stat(); rd_stat();
        mode_cfg = 8'h00;

        // R11 length write mid-block ignored
        push_seq(4, 8'hB0); ctl(16'h0201); ctl(16'h0401); req(4); idle(2);
        expect_got(2, 8'hB0, 1, "R11 mid-block write");
        ctl(16'h0080); ctl(16'h0000);

        // R9 event in same cycle as read stays pending
        push_seq(1, 8'h66); ctl(16'h0101);
        tx_req = 1'b1; stat_rd = 1'b1;
        @(negedge clk);
        tx_req = 1'b0; stat_rd = 1'b0;
        idle(1);
        chk(stat_word == 8'h80, "R9 same-cycle ready kept", stat_word, 8'h80);
        expect_got(1, 8'h66, 0, "R9 byte");
        rd_stat(); idle(1);
        chk(stat_word == 8'h00, "R9 final clear", stat_word, 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule